// File: doc/BRIEF.md
# Hamming Page ECC Engine

This block generates and checks single-error-correcting Hamming digests for a flash page. The page is made of 512-byte data chunks, and there are one, two or four of them. Bytes arrive on a byte stream with a valid/ready pair, a start-of-page marker and a chunk-count field that is sampled with the first byte. A mode input selects digest generation (writing a page) or digest checking (reading a page). The output stream repeats the input stream one cycle later. In generation mode the block also inserts the digests once the data area ends.

In generation mode the host sends only the data bytes and then any free spare bytes. Once the last data byte is accepted, the block drops `in_ready` and emits one 6-byte digest per chunk, in chunk order. It then raises `in_ready` again so that the spare bytes can pass through. In checking mode the host sends the whole stored page: the data area, then the stored digests in chunk order, then spare bytes. Each time the last byte of a chunk's stored digest arrives, the block pulses a status strobe. The strobe carries a 2-bit verdict and, when a data bit was repaired, the byte offset in the chunk together with an 8-bit mask that marks the bit to invert.

The digest holds 12 pairs of parity bits. Each pair covers one bit of the 12-bit position of a data bit within the chunk (byte index times 8 plus bit index). One bit of the pair is the parity over the positions where that index bit is 1, and the other over the positions where it is 0.

Top module: `hamming_page_ecc`

## Requirements
- R1: The page length is set by `in_chunks`, sampled with the start-of-page byte. 0 selects one chunk, 1 selects two, and 2 or 3 select four. Each chunk is 512 data bytes.
- R2: The digest of a chunk is 6 bytes. For k = 0..11, parity bit 2k+1 is the XOR of the data bits whose position has bit k set, and parity bit 2k is the XOR of those whose position has bit k clear. Here position = byte_index*8 + bit_index, and bit 0 of a byte is its LSB. Digest byte j (j = 0..2) holds parity bits 8j+7..8j, and digest bytes 3..5 are zero.
- R3: In generation mode (`in_mode` = 0), each accepted byte appears on `out_data` with `out_valid` one cycle after acceptance. After the last data byte, the digests of all chunks follow back to back, in chunk order and byte order, and `in_ready` is low for exactly 6 x chunks cycles.
- R4: Bytes accepted after the digest area are passed to the output unchanged. They take no part in ECC and cause no status strobe.
- R5: In checking mode (`in_mode` = 1), `stat_valid` pulses for one cycle in the cycle after the 6th stored digest byte of each chunk is accepted. This gives exactly one pulse per chunk, in chunk order.
- R6: If the stored digest matches the recomputed one, `stat_code` is 00 and `fix_index` and `fix_mask` are zero.
- R7: A single flipped data bit gives `stat_code` 01, `fix_index` equal to its byte offset in the chunk and `fix_mask` with only its bit set.
- R8: A single flipped bit in digest bytes 0..2 gives `stat_code` 01 with `fix_mask` zero. Digest bytes 3..5 are not checked.
- R9: Two flipped bits in a chunk's data or digest bytes 0..2 give `stat_code` 10 with `fix_mask` and `fix_index` zero. Code 11 is never produced.
- R10: During and after reset, `out_valid` and `stat_valid` are low and `in_ready` is high.
- R11: An accepted byte with `in_sop` high always begins a new page as data byte 0 of chunk 0, discarding a page in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_sop | input | 1 | Byte is the first data byte of a page |
| in_data | input | 8 | Input byte |
| in_chunks | input | 2 | Chunk-count code, sampled with the start-of-page byte |
| in_mode | input | 1 | 0 generate digests, 1 check digests; sampled with the start-of-page byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte: echoed input or inserted digest |
| stat_valid | output | 1 | One-cycle strobe per checked chunk |
| stat_code | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| fix_index | output | 9 | Byte offset of the repaired bit in the chunk |
| fix_mask | output | 8 | Bit to invert in that byte |

## Verification
The checks assume that a page starts with an `in_sop` byte and that the host does not raise `in_sop` again in the middle of a stored digest. Under that condition, two status strobes can never be closer than six accepted bytes. They also assume that the data fed during checking differs from what was written by at most the injected flips. The bench drives every page through a single task: it starts each page with `in_sop`, respects `in_ready`, and corrupts the data only through the six scenario kinds (clean, one data flip, one digest flip, two data flips, padding flip, two digest flips). For each chunk it computes the expected verdict from the injected scenario, not from a syndrome.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } ecc_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_DIG   = 2'd2,
    PH_SPARE = 2'd3
  } phase_e;

endpackage

// File: rtl/hpe_parity_acc.sv
module hpe_parity_acc #(
  parameter int BYTE_AW = 9,
  parameter int IDX_W   = BYTE_AW + 3,
  parameter int PAR_W   = 2 * IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [BYTE_AW-1:0] byte_idx,
  input  logic [7:0]         din,
  output logic [PAR_W-1:0]   par_next
);

  logic [PAR_W-1:0] par_q;
  logic [PAR_W-1:0] contrib;
  logic             bpar;
  logic [IDX_W-1:0] pair_x;

  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    for (int t = 0; t < 8; t++) m[t] = ((t >> k) & 1) == 1;
    return m;
  endfunction

  assign bpar = ^din;

  for (genvar g = 0; g < IDX_W; g++) begin : g_pair
    if (g < 3) begin : g_col
      assign contrib[2*g+1] = ^(din & col_mask(g));
      assign contrib[2*g]   = ^(din & ~col_mask(g));
    end else begin : g_line
      assign contrib[2*g+1] = bpar & byte_idx[g-3];
      assign contrib[2*g]   = bpar & ~byte_idx[g-3];
    end
    assign pair_x[g] = par_next[2*g+1] ^ par_next[2*g];
  end

  always_comb begin
    par_next = ((byte_idx == '0) ? '0 : par_q) ^ contrib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else if (en) par_q <= par_next;
  end

  // R2
  pair_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pair_x == '0 || pair_x == '1));

endmodule

// File: rtl/hpe_syn_dec.sv
module hpe_syn_dec import hpe_pkg::*; #(
  parameter int BYTE_AW = 9,
  parameter int IDX_W   = BYTE_AW + 3,
  parameter int PAR_W   = 2 * IDX_W
) (
  input  logic [PAR_W-1:0]   calc,
  input  logic [PAR_W-1:0]   stored,
  output ecc_stat_e          stat,
  output logic [BYTE_AW-1:0] fix_idx,
  output logic [7:0]         fix_mask
);

  logic [PAR_W-1:0] syn;
  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] pair_diff;
  int unsigned      ones;

  assign syn = calc ^ stored;

  for (genvar g = 0; g < IDX_W; g++) begin : g_pos
    assign pos[g]       = syn[2*g+1];
    assign pair_diff[g] = syn[2*g+1] ^ syn[2*g];
  end

  always_comb begin
    ones     = $countones(syn);
    stat     = ST_FATAL;
    fix_idx  = '0;
    fix_mask = '0;
    if (syn == '0) begin
      stat = ST_CLEAN;
    end else if (ones == 1) begin
      stat = ST_FIXED;
    end else if (&pair_diff) begin
      stat     = ST_FIXED;
      fix_idx  = pos[IDX_W-1:3];
      fix_mask = 8'(1) << pos[2:0];
    end
  end

endmodule

// File: rtl/hpe_ctrl.sv
module hpe_ctrl import hpe_pkg::*; #(
  parameter int CHUNK_BYTES = 512,
  parameter int MAX_CHUNKS  = 4,
  parameter int DIG_BYTES   = 6,
  parameter int CNT_W       = 2,
  parameter int BYTE_AW     = 9,
  parameter int CH_W        = 2,
  parameter int DG_W        = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic [CNT_W-1:0]   in_chunks,
  input  logic               in_mode,
  output logic               in_ready,
  output logic               take,
  output logic               start,
  output logic               page_open,
  output logic               data_en,
  output logic [BYTE_AW-1:0] byte_idx,
  output logic [CH_W-1:0]    chunk_idx,
  output logic               chunk_done,
  output logic               dig_en,
  output logic [DG_W-1:0]    dig_idx,
  output logic               dig_last,
  output logic               chk_mode
);

  phase_e             phase_q, phase_d;
  logic [BYTE_AW-1:0] byte_q, byte_d;
  logic [CH_W-1:0]    chunk_q, chunk_d;
  logic [DG_W-1:0]    dig_q, dig_d;
  logic               mode_q, mode_d;
  logic [CH_W-1:0]    lastc_q, lastc_d, lastc_in;

  always_comb begin
    lastc_in = CH_W'(MAX_CHUNKS - 1);
    for (int i = 0; i < CH_W; i++) begin
      if (int'(in_chunks) == i) lastc_in = CH_W'((1 << i) - 1);
    end
  end

  assign in_ready   = !(phase_q == PH_DIG && !mode_q);
  assign take       = in_valid & in_ready;
  assign start      = take & in_sop;
  assign page_open  = start | (phase_q != PH_IDLE);
  assign data_en    = take & (start | (phase_q == PH_DATA));
  assign byte_idx   = start ? '0 : byte_q;
  assign chunk_idx  = start ? '0 : chunk_q;
  assign chunk_done = data_en & (byte_idx == BYTE_AW'(CHUNK_BYTES - 1));
  assign dig_en     = (phase_q == PH_DIG) & !start & (mode_q ? take : 1'b1);
  assign dig_idx    = dig_q;
  assign dig_last   = dig_en & (dig_q == DG_W'(DIG_BYTES - 1));
  assign chk_mode   = mode_q;

  always_comb begin
    phase_d = phase_q;
    byte_d  = byte_q;
    chunk_d = chunk_q;
    dig_d   = dig_q;
    mode_d  = mode_q;
    lastc_d = lastc_q;
    if (start) begin
      phase_d = PH_DATA;
      byte_d  = BYTE_AW'(1);
      chunk_d = '0;
      dig_d   = '0;
      mode_d  = in_mode;
      lastc_d = lastc_in;
    end else begin
      case (phase_q)
        PH_DATA: begin
          if (data_en) begin
            if (chunk_done) begin
              byte_d = '0;
              if (chunk_q == lastc_q) begin
                phase_d = PH_DIG;
                chunk_d = '0;
                dig_d   = '0;
              end else begin
                chunk_d = chunk_q + 1'b1;
              end
            end else begin
              byte_d = byte_q + 1'b1;
            end
          end
        end
        PH_DIG: begin
          if (dig_en) begin
            if (dig_last) begin
              dig_d = '0;
              if (chunk_q == lastc_q) begin
                phase_d = PH_SPARE;
                chunk_d = '0;
              end else begin
                chunk_d = chunk_q + 1'b1;
              end
            end else begin
              dig_d = dig_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      byte_q  <= '0;
      chunk_q <= '0;
      dig_q   <= '0;
      mode_q  <= 1'b0;
      lastc_q <= '0;
    end else begin
      phase_q <= phase_d;
      byte_q  <= byte_d;
      chunk_q <= chunk_d;
      dig_q   <= dig_d;
      mode_q  <= mode_d;
      lastc_q <= lastc_d;
    end
  end

  // R1
  chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_q <= lastc_q);

  // R3
  dig_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dig_q <= DG_W'(DIG_BYTES - 1));

endmodule

// File: rtl/hamming_page_ecc.sv
module hamming_page_ecc import hpe_pkg::*; #(
  parameter int CHUNK_BYTES = 512,
  parameter int MAX_CHUNKS  = 4,
  parameter int DIG_BYTES   = 6,
  parameter int CNT_W       = 2,
  localparam int BYTE_AW    = $clog2(CHUNK_BYTES),
  localparam int IDX_W      = BYTE_AW + 3,
  localparam int PAR_W      = 2 * IDX_W,
  localparam int PAR_BYTES  = (PAR_W + 7) / 8,
  localparam int PAR_PAD    = PAR_BYTES * 8,
  localparam int DIG8       = DIG_BYTES * 8,
  localparam int CH_W       = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int DG_W       = $clog2(DIG_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sop,
  input  logic [7:0]         in_data,
  input  logic [CNT_W-1:0]   in_chunks,
  input  logic               in_mode,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               stat_valid,
  output logic [1:0]         stat_code,
  output logic [BYTE_AW-1:0] fix_index,
  output logic [7:0]         fix_mask
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic               take, start, page_open, data_en, chunk_done;
  logic               dig_en, dig_last, chk_mode;
  logic [BYTE_AW-1:0] byte_idx;
  logic [CH_W-1:0]    chunk_idx;
  logic [DG_W-1:0]    dig_idx;

  hpe_ctrl #(
    .CHUNK_BYTES(CHUNK_BYTES), .MAX_CHUNKS(MAX_CHUNKS), .DIG_BYTES(DIG_BYTES),
    .CNT_W(CNT_W), .BYTE_AW(BYTE_AW), .CH_W(CH_W), .DG_W(DG_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_sn), .in_valid(in_valid), .in_sop(in_sop),
    .in_chunks(in_chunks), .in_mode(in_mode), .in_ready(in_ready),
    .take(take), .start(start), .page_open(page_open), .data_en(data_en),
    .byte_idx(byte_idx), .chunk_idx(chunk_idx), .chunk_done(chunk_done),
    .dig_en(dig_en), .dig_idx(dig_idx), .dig_last(dig_last), .chk_mode(chk_mode)
  );

  logic [PAR_W-1:0] par_next;

  hpe_parity_acc #(.BYTE_AW(BYTE_AW), .IDX_W(IDX_W), .PAR_W(PAR_W)) acc_i (
    .clk(clk), .rst_n(rst_sn), .en(data_en), .byte_idx(byte_idx),
    .din(in_data), .par_next(par_next)
  );

  // computed digests, one per chunk
  logic [PAR_W-1:0] comp_q [MAX_CHUNKS];

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : g_store
    logic wr_en;
    assign wr_en = chunk_done && (chunk_idx == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) comp_q[g] <= '0;
      else if (wr_en) comp_q[g] <= par_next;
    end
  end

  // stored digest capture (read mode)
  logic             cap_en;
  logic [PAR_PAD-1:0] st_q, st_cur;

  assign cap_en = dig_en & chk_mode;

  for (genvar j = 0; j < PAR_BYTES; j++) begin : g_cap
    assign st_cur[8*j +: 8] = (cap_en && dig_idx == DG_W'(j)) ? in_data : st_q[8*j +: 8];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= '0;
    else if (cap_en) st_q <= st_cur;
  end

  ecc_stat_e          dec_stat;
  logic [BYTE_AW-1:0] dec_idx;
  logic [7:0]         dec_mask;

  hpe_syn_dec #(.BYTE_AW(BYTE_AW), .IDX_W(IDX_W), .PAR_W(PAR_W)) dec_i (
    .calc(comp_q[chunk_idx]), .stored(st_cur[PAR_W-1:0]),
    .stat(dec_stat), .fix_idx(dec_idx), .fix_mask(dec_mask)
  );

  // digest byte for generation mode
  logic [DIG8-1:0] dig_pad;
  logic [7:0]      dig_byte;

  always_comb begin
    dig_pad            = '0;
    dig_pad[PAR_W-1:0] = comp_q[chunk_idx];
    dig_byte           = dig_pad[{dig_idx, 3'b000} +: 8];
  end

  // output stream
  logic       ov_d, ov_q;
  logic [7:0] od_d, od_q;
  logic       od_en;

  always_comb begin
    ov_d  = 1'b0;
    od_d  = in_data;
    od_en = 1'b0;
    if (dig_en && !chk_mode) begin
      ov_d  = 1'b1;
      od_d  = dig_byte;
      od_en = 1'b1;
    end else if (take && page_open) begin
      ov_d  = 1'b1;
      od_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= ov_d;
      if (od_en) od_q <= od_d;
    end
  end

  // status strobe
  logic               sv_d, sv_q;
  logic [1:0]         sc_q;
  logic [BYTE_AW-1:0] fi_q;
  logic [7:0]         fm_q;

  assign sv_d = dig_last & chk_mode;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sv_q <= 1'b0;
      sc_q <= 2'b00;
      fi_q <= '0;
      fm_q <= '0;
    end else begin
      sv_q <= sv_d;
      if (sv_d) begin
        sc_q <= dec_stat;
        fi_q <= dec_idx;
        fm_q <= dec_mask;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_data   = od_q;
  assign stat_valid = sv_q;
  assign stat_code  = sc_q;
  assign fix_index  = fi_q;
  assign fix_mask   = fm_q;

  // R9
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    stat_valid |-> stat_code != 2'b11);

  // R6
  clean_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (stat_valid && stat_code == 2'b00) |-> (fix_mask == '0 && fix_index == '0));

  // R7
  fix_mask_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (stat_valid && stat_code == 2'b01) |-> $countones(fix_mask) <= 1);

  // R9
  fatal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (stat_valid && stat_code == 2'b10) |-> (fix_mask == '0 && fix_index == '0));

  // R3
  stall_emits_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_ready |=> out_valid);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    stat_valid |=> !stat_valid);

endmodule

// File: tb/hamming_page_ecc_tb.sv
module hamming_page_ecc_tb_top;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_sop, in_mode;
  logic [7:0] in_data;
  logic [1:0] in_chunks;
  logic       in_ready, out_valid, stat_valid;
  logic [7:0] out_data, fix_mask;
  logic [1:0] stat_code;
  logic [8:0] fix_index;

  hamming_page_ecc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .in_chunks(in_chunks), .in_mode(in_mode),
    .out_valid(out_valid), .out_data(out_data), .stat_valid(stat_valid),
    .stat_code(stat_code), .fix_index(fix_index), .fix_mask(fix_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int cyc = 0;
  int last_acc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  localparam int OQ = 2200;
  logic [7:0] oq [OQ];
  int outn, stn, rdylow;
  logic [1:0] s_code [4];
  logic [8:0] s_idx  [4];
  logic [7:0] s_mask [4];
  int         s_cyc  [4];

  always @(negedge clk) begin
    if (out_valid) begin
      if (outn < OQ) oq[outn] = out_data;
      outn++;
    end
    if (!in_ready) rdylow++;
    if (stat_valid) begin
      if (stn < 4) begin
        s_code[stn] = stat_code;
        s_idx[stn]  = fix_index;
        s_mask[stn] = fix_mask;
        s_cyc[stn]  = cyc;
      end
      stn++;
    end
  end

  logic [7:0]  pg [2048];
  logic [47:0] dv [4];
  int          sc [4];
  int          pa [4];
  int          pb [4];
  int          exp_cyc [4];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nch(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [23:0] calc(input int c);
    logic [23:0] p;
    p = '0;
    for (int b = 0; b < 512; b++)
      for (int t = 0; t < 8; t++)
        if (pg[c*512+b][t]) begin
          int i;
          i = b*8 + t;
          for (int k = 0; k < 12; k++)
            if (((i >> k) & 1) == 1) p[2*k+1] = ~p[2*k+1];
            else p[2*k] = ~p[2*k];
        end
    return p;
  endfunction

  task automatic push(input logic [7:0] b, input logic s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    in_sop   = s;
    last_acc = cyc + 1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    outn = 0; stn = 0; rdylow = 0;
  endtask

  // fill: 0 random, 1 zeros, 2 ones
  task automatic fill(input int n, input int kind);
    for (int i = 0; i < n*512; i++)
      pg[i] = (kind == 1) ? 8'h00 : (kind == 2) ? 8'hFF : 8'($urandom);
  endtask

  task automatic run_write(input logic [1:0] code, input int kind);
    int n, bad;
    logic [23:0] d;
    n = nch(code);
    fill(n, kind);
    clear_mon();
    in_mode = 1'b0; in_chunks = code;
    for (int i = 0; i < n*512; i++) push(pg[i], i == 0);
    for (int i = 0; i < 5; i++) push(8'h5A + 8'(i), 1'b0);
    idle(12);
    check(outn == n*518 + 5, "R3 output byte count", outn, n*518 + 5);
    check(rdylow == 6*n, "R3 in_ready low cycles", rdylow, 6*n);
    check(stn == 0, "R4 no strobe in generation mode", stn, 0);
    bad = 0;
    for (int i = 0; i < n*512; i++) if (oq[i] !== pg[i]) bad++;
    check(bad == 0, "R3 data echo mismatches", bad, 0);
    for (int c = 0; c < n; c++) begin
      d = calc(c);
      bad = 0;
      for (int j = 0; j < 6; j++) begin
        logic [7:0] e;
        e = (j < 3) ? d[8*j +: 8] : 8'h00;
        if (oq[n*512 + c*6 + j] !== e) bad++;
      end
      check(bad == 0, "R2 digest bytes wrong", bad, 0);
    end
    bad = 0;
    for (int i = 0; i < 5; i++) if (oq[n*518 + i] !== 8'h5A + 8'(i)) bad++;
    check(bad == 0, "R4 spare echo mismatches", bad, 0);
  endtask

  // scenarios: 0 clean, 1 data flip pa, 2 digest flip pa, 3 data flips pa/pb,
  // 4 padding flip, 5 digest flips pa/pb
  task automatic run_read(input logic [1:0] code, input int kind);
    int n;
    n = nch(code);
    fill(n, kind);
    for (int c = 0; c < n; c++) begin
      dv[c] = {24'h0, calc(c)};
      case (sc[c])
        1: pg[c*512 + pa[c]/8] ^= 8'(1 << (pa[c] % 8));
        2: dv[c] ^= 48'h1 << pa[c];
        3: begin
          pg[c*512 + pa[c]/8] ^= 8'(1 << (pa[c] % 8));
          pg[c*512 + pb[c]/8] ^= 8'(1 << (pb[c] % 8));
        end
        4: dv[c] ^= 48'h1 << (24 + pa[c] % 24);
        5: dv[c] ^= (48'h1 << pa[c]) ^ (48'h1 << pb[c]);
        default: ;
      endcase
    end
    clear_mon();
    in_mode = 1'b1; in_chunks = code;
    for (int i = 0; i < n*512; i++) push(pg[i], i == 0);
    for (int c = 0; c < n; c++) begin
      for (int j = 0; j < 6; j++) push(dv[c][8*j +: 8], 1'b0);
      exp_cyc[c] = last_acc;
    end
    for (int i = 0; i < 3; i++) push(8'hC3, 1'b0);
    idle(8);
    check(stn == n, "R5 strobe count", stn, n);
    for (int c = 0; c < n && c < stn; c++) begin
      logic [1:0] ec; logic [8:0] ei; logic [7:0] em;
      ec = 2'b00; ei = '0; em = '0;
      if (sc[c] == 1) begin ec = 2'b01; ei = 9'(pa[c] / 8); em = 8'(1 << (pa[c] % 8)); end
      else if (sc[c] == 2) ec = 2'b01;
      else if (sc[c] == 3 || sc[c] == 5) ec = 2'b10;
      check(s_cyc[c] == exp_cyc[c], "R5 strobe cycle", s_cyc[c], exp_cyc[c]);
      case (sc[c])
        1: begin
          check(s_code[c] == ec, "R7 code", s_code[c], ec);
          check(s_idx[c] == ei && s_mask[c] == em, "R7 index/mask",
                {s_idx[c], s_mask[c]}, {ei, em});
        end
        2: check(s_code[c] == ec && s_mask[c] == 0, "R8 digest flip", {s_code[c], s_mask[c]}, {ec, em});
        4: check(s_code[c] == ec && s_mask[c] == 0, "R8 padding ignored", {s_code[c], s_mask[c]}, {ec, em});
        3, 5: check(s_code[c] == ec && s_mask[c] == 0 && s_idx[c] == 0, "R9 double flip",
                    {s_code[c], s_idx[c], s_mask[c]}, {ec, ei, em});
        default: check(s_code[c] == ec && s_mask[c] == 0 && s_idx[c] == 0, "R6 clean",
                       {s_code[c], s_idx[c], s_mask[c]}, {ec, ei, em});
      endcase
    end
  endtask

  task automatic rand_scen(input int c);
    sc[c] = int'($urandom % 6);
    if (sc[c] == 1 || sc[c] == 3) begin
      pa[c] = int'($urandom % 4096);
      pb[c] = (pa[c] + 1 + int'($urandom % 4095)) % 4096;
    end else begin
      pa[c] = int'($urandom % 24);
      pb[c] = (pa[c] + 1 + int'($urandom % 23)) % 24;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    in_valid = 0; in_sop = 0; in_mode = 0; in_data = 0; in_chunks = 0;
    clear_mon();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R10: during reset
    check(!out_valid && !stat_valid, "R10 outputs idle in reset", {out_valid, stat_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(!out_valid && !stat_valid, "R10 outputs idle after reset", {out_valid, stat_valid}, 0);

    // generation: R1 chunk codes, R2 digest, R3 order, R4 spare
    run_write(2'd0, 0);
    run_write(2'd1, 1);
    run_write(2'd2, 0);
    run_write(2'd3, 2);   // R1: code 3 means four chunks

    // directed checking pages
    sc = '{1, 0, 2, 3}; pa = '{0, 0, 23, 0}; pb = '{0, 0, 0, 4095};
    run_read(2'd2, 0);
    sc = '{1, 4, 5, 0}; pa = '{4095, 7, 0, 0}; pb = '{0, 5, 23, 0};
    run_read(2'd3, 0);
    sc = '{0, 0, 0, 0}; pa = '{0, 0, 0, 0}; pb = '{0, 0, 0, 0};
    run_read(2'd0, 1);

    // R11: abandon a page midway, then restart
    in_mode = 1'b1; in_chunks = 2'd2;
    for (int i = 0; i < 100; i++) push(8'($urandom), i == 0);
    sc[0] = 1; pa[0] = 1234;
    run_read(2'd0, 0);
    check(stn == 1, "R11 restart gives one chunk", stn, 1);

    // random checking pages
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 4; c++) rand_scen(c);
      run_read(2'($urandom % 4), 0);
    end

    finish_run();
  end

endmodule